// File: doc/BRIEF.md
# Multi-Word Frame Count and Time Slice Source

This block supplies two digital sources for a PCM frame sequencer that spread their contents over several words. The sequencer presents a one-cycle select strobe together with a digital mux address. Address 240 returns the next word of a major-frame counter. Address 241 returns the next slice of a 64-bit BCD time-of-day value. Every other address belongs to some other source, so this block ignores it.

The major-frame counter advances once on each frame-end pulse. Its length is the smallest multiple of the word size that is at least 20 bits. At the start of each major frame the counter is copied into a holding register, and successive selections read that copy most significant word first. The time value is copied at the same moment and is sent least significant bit first in word-size slices. Once all 64 bits have gone out, the slices are zero. Both read positions return to their first word at every frame start, so all words read within one frame belong to the same snapshot.

The word size (6 to 12 bits) comes from the frame format. The result sits right-justified in a 12-bit output that is registered one cycle after the strobe.

Top module: `aux_word_source`

## Requirements
- R1: After reset, word_valid and word_out are 0, the counter and both snapshots are 0, and both read positions point at their first word.
- R2: A strobe with address 240 or 241 raises word_valid for exactly the following cycle, with the data in word_out. A strobe with any other address leaves word_valid low and word_out zero, and moves neither read position.
- R3: The counter length in bits for word sizes 6, 7, 8, 9, 10, 11, 12 is 24, 21, 24, 27, 20, 22, 24. This means 4, 3, 3, 3, 2, 2, 2 words per complete read.
- R4: Each frame_end pulse adds one to the counter. The counter returns to 0 after reaching 2^length − 1.
- R5: frame_start copies the counter into the snapshot, including an increment from a frame_end in the same cycle. Address-240 reads return snapshot words most significant first. After the least significant word, the next read returns the most significant word again.
- R6: frame_start copies time_in. The k-th address-241 read after a frame start returns snapshot bits [k·w +: w], where w is the word size.
- R7: Snapshot bits beyond bit 63 are returned as zeros. Once all 64 bits have been sent, every later address-241 read in the frame returns 0.
- R8: frame_start returns both read positions to their first word, even when a read sequence is only partly done.
- R9: While word_valid is high, word_out bits at and above the word size are zero.
- R10: Changes on time_in between frame starts do not alter the words returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_bits | input | 4 | Word size in bits, 6 to 12 |
| frame_start | input | 1 | Major-frame start pulse: take snapshots, rewind read positions |
| frame_end | input | 1 | Major-frame end pulse: advance the counter |
| sel_strobe | input | 1 | Select strobe from the frame sequencer |
| sel_addr | input | 8 | Digital mux address accompanying the strobe |
| time_in | input | 64 | Parallel BCD time-of-day value |
| word_valid | output | 1 | High for one cycle with a returned word |
| word_out | output | 12 | Returned word, right-justified |

## Verification
The bench builds two copies of the block. One uses the default 20-bit minimum counter length, so the stated length table and the most-significant-first order can be checked at every word size. The other uses an 8-bit minimum, so at word size 8 the counter wraps after 256 frames. That brings the return to zero within reach of a short run, which the default build cannot do. Both copies share their inputs, so each frame pattern drives both.

// File: rtl/aux_word_pkg.sv
package aux_word_pkg;

   // Counter length: smallest multiple of the word size not below min_bits
   function automatic int cnt_len(input int wb, input int min_bits);
      return ((min_bits + wb - 1) / wb) * wb;
   endfunction

   function automatic int max_cnt_len(input int min_wb, input int max_wb, input int min_bits);
      int best;
      best = 0;
      for (int w = min_wb; w <= max_wb; w++) begin
         if (cnt_len(w, min_bits) > best) best = cnt_len(w, min_bits);
      end
      return best;
   endfunction

   function automatic int max_words(input int min_wb, input int max_wb, input int min_bits);
      int best;
      best = 0;
      for (int w = min_wb; w <= max_wb; w++) begin
         if (cnt_len(w, min_bits) / w > best) best = cnt_len(w, min_bits) / w;
      end
      return best;
   endfunction

endpackage

// File: rtl/aux_frame_counter.sv
module aux_frame_counter #(
   parameter int MIN_WB       = 6,
   parameter int MAX_WB       = 12,
   parameter int WB_W         = 4,
   parameter int MIN_CNT_BITS = 20,
   parameter int CNT_W        = 27,
   parameter int IDX_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WB_W-1:0]   wb,
   input  logic [MAX_WB-1:0] wb_mask,
   input  logic              frame_end,
   input  logic              frame_start,
   input  logic              rd,
   output logic [MAX_WB-1:0] word,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  hold,
   output logic [IDX_W-1:0]  idx
);
   localparam int LUT_N = 2 ** WB_W;

   logic [CNT_W-1:0] lenmask_lut [LUT_N];
   logic [IDX_W-1:0] words_lut   [LUT_N];

   // Per-word-size length mask and word count, fixed at elaboration
   for (genvar w = 0; w < LUT_N; w++) begin : g_lut
      localparam int WEFF = (w < MIN_WB) ? MIN_WB : ((w > MAX_WB) ? MAX_WB : w);
      localparam int LEN  = aux_word_pkg::cnt_len(WEFF, MIN_CNT_BITS);
      assign lenmask_lut[w] = CNT_W'((64'd1 << LEN) - 64'd1);
      assign words_lut[w]   = IDX_W'(LEN / WEFF);
   end

   logic [CNT_W-1:0] count_q, hold_q, count_nxt, len_mask;
   logic [IDX_W-1:0] idx_q, words_cur;
   int               shift_amt;

   assign len_mask  = lenmask_lut[wb];
   assign words_cur = words_lut[wb];

   always_comb begin
      count_nxt = count_q;
      if (frame_end) count_nxt = (count_q + CNT_W'(1)) & len_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         hold_q  <= '0;
         idx_q   <= '0;
      end else begin
         if (frame_end) count_q <= count_nxt;
         if (frame_start) begin
            hold_q <= count_nxt & len_mask;
            idx_q  <= '0;
         end else if (rd) begin
            idx_q <= (idx_q >= words_cur - 1'b1) ? '0 : idx_q + 1'b1;
         end
      end
   end

   // High word first: the slice offset shrinks as the index grows
   always_comb begin
      shift_amt = (int'(words_cur) - 1 - int'(idx_q)) * int'(wb);
      if (shift_amt < 0) shift_amt = 0;
      word = MAX_WB'(hold_q >> shift_amt) & wb_mask;
   end

   assign count = count_q;
   assign hold  = hold_q;
   assign idx   = idx_q;
endmodule

// File: rtl/aux_time_slicer.sv
module aux_time_slicer #(
   parameter int TIME_W = 64,
   parameter int MAX_WB = 12,
   parameter int WB_W   = 4,
   parameter int PTR_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WB_W-1:0]   wb,
   input  logic [MAX_WB-1:0] wb_mask,
   input  logic              frame_start,
   input  logic              rd,
   input  logic [TIME_W-1:0] time_in,
   output logic [MAX_WB-1:0] word,
   output logic [PTR_W-1:0]  ptr
);
   logic [TIME_W-1:0] hold_q;
   logic [PTR_W-1:0]  ptr_q, ptr_nxt;
   int                sum;

   // Pointer saturates at TIME_W so later slices are all zero fill
   always_comb begin
      sum = int'(ptr_q) + int'(wb);
      if (sum >= TIME_W) ptr_nxt = PTR_W'(TIME_W);
      else               ptr_nxt = PTR_W'(sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         ptr_q  <= '0;
      end else if (frame_start) begin
         hold_q <= time_in;
         ptr_q  <= '0;
      end else if (rd) begin
         ptr_q <= ptr_nxt;
      end
   end

   assign word = MAX_WB'(hold_q >> ptr_q) & wb_mask;
   assign ptr  = ptr_q;
endmodule

// File: rtl/aux_word_out.sv
module aux_word_out #(
   parameter int ADDR_W    = 8,
   parameter int CNT_ADDR  = 240,
   parameter int TIME_ADDR = 241,
   parameter int MAX_WB    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_strobe,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic [MAX_WB-1:0] cnt_word,
   input  logic [MAX_WB-1:0] time_word,
   output logic              rd_cnt,
   output logic              rd_time,
   output logic              word_valid,
   output logic [MAX_WB-1:0] word_out
);
   assign rd_cnt  = sel_strobe && (sel_addr == ADDR_W'(CNT_ADDR));
   assign rd_time = sel_strobe && (sel_addr == ADDR_W'(TIME_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_valid <= 1'b0;
         word_out   <= '0;
      end else begin
         word_valid <= rd_cnt || rd_time;
         if (rd_cnt)       word_out <= cnt_word;
         else if (rd_time) word_out <= time_word;
         else              word_out <= '0;
      end
   end
endmodule

// File: rtl/aux_word_source.sv
module aux_word_source #(
   parameter int ADDR_W       = 8,
   parameter int CNT_ADDR     = 240,
   parameter int TIME_ADDR    = 241,
   parameter int MIN_WB       = 6,
   parameter int MAX_WB       = 12,
   parameter int MIN_CNT_BITS = 20,
   parameter int TIME_W       = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(MAX_WB+1)-1:0]   word_bits,
   input  logic                          frame_start,
   input  logic                          frame_end,
   input  logic                          sel_strobe,
   input  logic [ADDR_W-1:0]             sel_addr,
   input  logic [TIME_W-1:0]             time_in,
   output logic                          word_valid,
   output logic [MAX_WB-1:0]             word_out
);
   localparam int WB_W  = $clog2(MAX_WB + 1);
   localparam int CNT_W = aux_word_pkg::max_cnt_len(MIN_WB, MAX_WB, MIN_CNT_BITS);
   localparam int IDX_W = $clog2(aux_word_pkg::max_words(MIN_WB, MAX_WB, MIN_CNT_BITS) + 1);
   localparam int PTR_W = $clog2(TIME_W + 1);

   if (MIN_WB < 1 || MAX_WB < MIN_WB) begin : g_bad_wb
      $error("word size range is empty");
   end
   if (CNT_ADDR == TIME_ADDR) begin : g_bad_addr
      $error("counter and time addresses collide");
   end
   if (CNT_W > 63 || CNT_W < MAX_WB) begin : g_bad_cnt
      $error("counter width out of supported range");
   end

   logic [WB_W-1:0]   wb_c;
   logic [MAX_WB-1:0] wb_mask, cnt_word, time_word;
   logic              rd_cnt, rd_time;
   logic [CNT_W-1:0]  cnt_value, cnt_hold;
   logic [IDX_W-1:0]  cnt_idx;
   logic [PTR_W-1:0]  time_ptr;

   always_comb begin
      if (word_bits < WB_W'(MIN_WB))      wb_c = WB_W'(MIN_WB);
      else if (word_bits > WB_W'(MAX_WB)) wb_c = WB_W'(MAX_WB);
      else                                wb_c = word_bits;
   end

   always_comb begin
      for (int i = 0; i < MAX_WB; i++) wb_mask[i] = (i < int'(wb_c));
   end

   aux_frame_counter #(
      .MIN_WB(MIN_WB), .MAX_WB(MAX_WB), .WB_W(WB_W),
      .MIN_CNT_BITS(MIN_CNT_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .wb(wb_c), .wb_mask(wb_mask),
      .frame_end(frame_end), .frame_start(frame_start), .rd(rd_cnt),
      .word(cnt_word), .count(cnt_value), .hold(cnt_hold), .idx(cnt_idx)
   );

   aux_time_slicer #(
      .TIME_W(TIME_W), .MAX_WB(MAX_WB), .WB_W(WB_W), .PTR_W(PTR_W)
   ) u_time (
      .clk(clk), .rst_n(rst_n), .wb(wb_c), .wb_mask(wb_mask),
      .frame_start(frame_start), .rd(rd_time), .time_in(time_in),
      .word(time_word), .ptr(time_ptr)
   );

   aux_word_out #(
      .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .TIME_ADDR(TIME_ADDR), .MAX_WB(MAX_WB)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .sel_strobe(sel_strobe), .sel_addr(sel_addr),
      .cnt_word(cnt_word), .time_word(time_word),
      .rd_cnt(rd_cnt), .rd_time(rd_time),
      .word_valid(word_valid), .word_out(word_out)
   );
endmodule

// File: rtl/aux_word_chk.sv
module aux_word_chk #(
   parameter int ADDR_W    = 8,
   parameter int CNT_ADDR  = 240,
   parameter int TIME_ADDR = 241,
   parameter int MAX_WB    = 12,
   parameter int WB_W      = 4,
   parameter int CNT_W     = 27,
   parameter int IDX_W     = 3,
   parameter int PTR_W     = 7,
   parameter int TIME_W    = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WB_W-1:0]   word_bits,
   input logic              frame_start,
   input logic              frame_end,
   input logic              sel_strobe,
   input logic [ADDR_W-1:0] sel_addr,
   input logic              word_valid,
   input logic [MAX_WB-1:0] word_out,
   input logic [CNT_W-1:0]  cnt_value,
   input logic [CNT_W-1:0]  cnt_hold,
   input logic [IDX_W-1:0]  cnt_idx,
   input logic [PTR_W-1:0]  time_ptr
);
   logic hit;
   assign hit = sel_strobe && (sel_addr == ADDR_W'(CNT_ADDR) || sel_addr == ADDR_W'(TIME_ADDR));

   a_r2_valid_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> word_valid);
   a_r2_quiet_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> !word_valid);
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> word_out == '0);
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (word_out >> $past(word_bits)) == '0);
   a_r4_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(cnt_value));
   a_r4_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> cnt_value != $past(cnt_value));
   a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(cnt_hold));
   a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cnt_idx == '0 && time_ptr == '0));
   a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(time_ptr) <= TIME_W);
endmodule

bind aux_word_source aux_word_chk #(
   .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .TIME_ADDR(TIME_ADDR), .MAX_WB(MAX_WB),
   .WB_W(WB_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .TIME_W(TIME_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .word_bits(word_bits), .frame_start(frame_start),
   .frame_end(frame_end), .sel_strobe(sel_strobe), .sel_addr(sel_addr),
   .word_valid(word_valid), .word_out(word_out), .cnt_value(cnt_value),
   .cnt_hold(cnt_hold), .cnt_idx(cnt_idx), .time_ptr(time_ptr)
);

// File: tb/aux_word_source_test.sv
module aux_word_source_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  word_bits = 4'd8;
   logic        frame_start = 1'b0, frame_end = 1'b0, sel_strobe = 1'b0;
   logic [7:0]  sel_addr = 8'd0;
   logic [63:0] time_in = '0;
   logic        wv_a, wv_b;
   logic [11:0] wo_a, wo_b;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   longint unsigned cm = 0, cs = 0, hm = 0, hs = 0;
   logic [63:0] ht;
   logic        rv_a, rv_b;
   logic [11:0] rw_a, rw_b;

   always #4 clk = ~clk;

   aux_word_source uut (
      .clk(clk), .rst_n(rst_n), .word_bits(word_bits), .frame_start(frame_start),
      .frame_end(frame_end), .sel_strobe(sel_strobe), .sel_addr(sel_addr),
      .time_in(time_in), .word_valid(wv_a), .word_out(wo_a));

   aux_word_source #(.MIN_CNT_BITS(8)) uut_short (
      .clk(clk), .rst_n(rst_n), .word_bits(word_bits), .frame_start(frame_start),
      .frame_end(frame_end), .sel_strobe(sel_strobe), .sel_addr(sel_addr),
      .time_in(time_in), .word_valid(wv_b), .word_out(wo_b));

   // {word size, frame_end pulses, time value}
   localparam logic [75:0] VEC [8] = '{
      {4'd6,  8'd70,  64'h0123_4567_89AB_CDEF},
      {4'd7,  8'd5,   64'h0000_0364_2359_5999},
      {4'd8,  8'd30,  64'hFEDC_BA98_7654_3210},
      {4'd9,  8'd12,  64'h0000_0123_1447_3821},
      {4'd10, 8'd40,  64'h8000_0000_0000_0001},
      {4'd11, 8'd3,   64'h0000_0299_0001_0507},
      {4'd12, 8'd100, 64'hA5A5_5A5A_0F0F_F0F0},
      {4'd6,  8'd1,   64'h0000_0000_0000_0FFF}
   };

   function automatic int len_def(input int w);
      case (w)
         6: return 24;  7: return 21;  8: return 24;  9: return 27;
         10: return 20; 11: return 22; default: return 24;
      endcase
   endfunction

   function automatic int len_short(input int w);
      case (w)
         6: return 12; 7: return 14; default: return w;
      endcase
   endfunction

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_end(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_end = 1'b1;
         cm = (cm + 1) % (64'd1 << len_def(word_bits));
         cs = (cs + 1) % (64'd1 << len_short(word_bits));
         @(negedge clk);
         frame_end = 1'b0;
      end
   endtask

   task automatic start_frame(input logic [63:0] t);
      @(negedge clk);
      frame_start = 1'b1;
      time_in = t;
      hm = cm % (64'd1 << len_def(word_bits));
      hs = cs % (64'd1 << len_short(word_bits));
      ht = t;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      sel_strobe = 1'b1;
      sel_addr = a;
      @(negedge clk);
      sel_strobe = 1'b0;
      rv_a = wv_a; rw_a = wo_a; rv_b = wv_b; rw_b = wo_b;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 valid after reset", wv_a, 0);
      check("R1 word after reset", wo_a, 0);
      rst_n = 1'b1;
      rd(8'd240);
      check("R1 counter zero valid", rv_a, 1);
      check("R1 counter zero", rw_a, 0);
      rd(8'd241);
      check("R1 time zero", rw_a, 0);

      // Table walk
      for (int v = 0; v < 8; v++) begin
         int w, nw, nt;
         longint unsigned mask;
         w = int'(VEC[v][75:72]);
         word_bits = VEC[v][75:72];
         mask = (64'd1 << w) - 1;
         pulse_end(int'(VEC[v][71:64]));
         start_frame(VEC[v][63:0]);
         time_in = ~VEC[v][63:0];          // R10: later input changes ignored
         rd(8'd250);
         check("R2 foreign address valid", rv_a, 0);
         check("R2 foreign address word", rw_a, 0);
         nw = len_def(w) / w;
         for (int i = 0; i <= nw; i++) begin
            int k;
            k = (i == nw) ? 0 : i;
            rd(8'd240);
            check("R2 counter valid", rv_a, 1);
            check("R3 R5 counter word", rw_a, (hm >> ((nw - 1 - k) * w)) & mask);
         end
         nt = (64 + w - 1) / w + 1;
         for (int k = 0; k < nt; k++) begin
            rd(8'd241);
            if (k * w < 64) check("R6 R10 time slice", rw_a, (ht >> (k * w)) & mask);
            else            check("R7 zero fill", rw_a, 0);
            check("R9 upper bits", rw_a >> w, 0);
         end
      end

      // R5: frame_end and frame_start in one cycle
      word_bits = 4'd12;
      @(negedge clk);
      frame_end = 1'b1; frame_start = 1'b1; time_in = 64'h1234;
      cm = (cm + 1) % (64'd1 << 24);
      cs = (cs + 1) % (64'd1 << 12);
      hm = cm; hs = cs;
      @(negedge clk);
      frame_end = 1'b0; frame_start = 1'b0;
      rd(8'd240);
      check("R5 same-cycle high word", rw_a, (hm >> 12) & 12'hFFF);
      rd(8'd240);
      check("R5 same-cycle low word", rw_a, hm & 12'hFFF);

      // R8: rewind mid-sequence
      rd(8'd241);
      check("R8 first slice", rw_a, 12'h234);
      rd(8'd240);
      start_frame(64'h0000_0000_0000_0ABC);
      rd(8'd241);
      check("R8 time rewound", rw_a, 12'hABC);
      rd(8'd240);
      check("R8 counter rewound", rw_a, (hm >> 12) & 12'hFFF);

      // R4: wrap on the short build at word size 8
      word_bits = 4'd8;
      pulse_end(int'((255 - (cs % 256)) % 256));
      start_frame(64'd0);
      rd(8'd240);
      check("R4 short counter at top", rw_b, 255);
      pulse_end(1);
      start_frame(64'd0);
      rd(8'd240);
      check("R4 short counter wrapped", rw_b, 0);
      check("R4 default counter high word", rw_a, (hm >> 16) & 8'hFF);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule